// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets synchronous logic read and write an asynchronous static RAM of 262,144 words of 4 bits. The host side uses a request/ready handshake: while `host_ready` is high, a one-cycle `host_req` starts one access. The access carries an address, a direction flag and write data. Read data comes back with a one-cycle `host_rvalid` strobe.

The memory side drives active-low chip select, write enable and output enable, plus the address. The bidirectional 4-bit data bus is split into an output value, an output enable for the pad driver and an input value, so the tri-state buffer lives in the pad ring.

Every memory timing limit is a parameter in nanoseconds. Each one is rounded up to whole clock cycles using the clock-period parameter:

- Read length is the largest of the read cycle time, the address access time and the output-enable access time.
- Bus turnaround is the output-disable-to-high-Z time, and never less than one cycle.
- Write-enable pulse length is the largest of the pulse width, chip-select-to-end, address-to-end and data setup times. It is then stretched so that the turnaround plus the pulse covers the write cycle time.

Output enable is always held high during writes, so the shorter write pulse limit applies.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released: `host_ready`=1, `sram_cs_n`=`sram_we_n`=`sram_oe_n`=1, `sram_dq_oe`=0 and `host_rvalid`=0.
- R2: A request is taken only at a clock edge where both `host_req` and `host_ready` are high. `host_ready` is low from that edge until the access ends. A request made while `host_ready` is low starts nothing and changes no memory pin.
- R3: For a read, the memory pins are cs_n=0, oe_n=0, we_n=1 for exactly RD cycles. With the default parameters, RD = max(ceil(12/10), ceil(12/10), ceil(6/10)) = 2. The bus value is captured at the edge that ends the last of these cycles. In the next cycle `host_ready`=1, the memory pins are all high, and `host_rdata` holds the word stored at that address.
- R4: For a write, oe_n stays 1 and cs_n stays 0 for TA cycles with we_n=1. Then we_n=0 for WP cycles. Then there is one recovery cycle with cs_n=we_n=1 and ready still low. With the defaults, TA = max(ceil(6/10),1) = 1 and WP = max(ceil(8/10), ceil(12/10)-TA, 1) = 1. we_n is never low while cs_n is high.
- R5: `sram_dq_oe` is never high while `sram_oe_n` is low. It rises only after `sram_oe_n` has been high for at least TA cycles.
- R6: During every cycle with we_n=0, `sram_dq_oe`=1 and `sram_dq_o` equals the accepted write data, unchanged for the whole pulse.
- R7: `sram_addr` takes the host address at the accept edge. It holds that value until the next accepted request, including through the write recovery cycle.
- R8: `host_rvalid` is high for exactly one cycle per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Start an access (sampled only when ready) |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 4 | Write data |
| host_ready | output | 1 | Controller idle and able to accept |
| host_rdata | output | 4 | Captured read data |
| host_rvalid | output | 1 | One-cycle strobe: host_rdata is new |
| sram_cs_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_addr | output | 18 | Memory address |
| sram_dq_o | output | 4 | Value for the data pad driver |
| sram_dq_oe | output | 1 | Data pad driver enable |
| sram_dq_i | input | 4 | Value seen on the data pads |

## Verification
A wrong state or a miscounted timer changes the strobe pattern at once. The cycle after a bad transition shows a wrong combination of ready, chip select, write enable, output enable and pad enable. A write that reaches its pulse without enough turnaround shows the pad driver on while output enable is low, or too soon after it rises. A mis-held address or write-data register shows up within the same access as a wrong `sram_addr` or `sram_dq_o`. A lost capture shows up on the next read of that address as a wrong `host_rdata`.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_TURN   = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WREC   = 3'd4
  } seq_state_e;

  // ceiling of ns over the clock period
  function automatic int ns_to_cyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int rd_cycles(input int period, input int t_rc,
                                   input int t_aa, input int t_oe);
    return max2(1, max2(ns_to_cyc(t_rc, period),
                        max2(ns_to_cyc(t_aa, period), ns_to_cyc(t_oe, period))));
  endfunction

  function automatic int ta_cycles(input int period, input int t_ohz);
    return max2(1, ns_to_cyc(t_ohz, period));
  endfunction

  function automatic int wp_cycles(input int period, input int t_wp, input int t_cw,
                                   input int t_aw, input int t_dw, input int t_wc,
                                   input int ta);
    int base;
    base = max2(max2(ns_to_cyc(t_wp, period), ns_to_cyc(t_cw, period)),
                max2(ns_to_cyc(t_aw, period), ns_to_cyc(t_dw, period)));
    return max2(1, max2(base, ns_to_cyc(t_wc, period) - ta));
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int RD_CYC = 2,
  parameter int TA_CYC = 1,
  parameter int WP_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic is_write,
  output logic ready,
  output logic cs_n,
  output logic we_n,
  output logic oe_n,
  output logic drive,
  output logic capture
);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);

  seq_state_e       st, nxt;
  logic             ld, zero;
  logic [CNT_W-1:0] ld_val;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .zero(zero)
  );

  always_comb begin
    nxt     = st;
    ld      = 1'b0;
    ld_val  = '0;
    capture = 1'b0;
    case (st)
      ST_IDLE: if (accept) begin
        ld = 1'b1;
        if (is_write) begin nxt = ST_TURN; ld_val = TA_LD; end
        else          begin nxt = ST_READ; ld_val = RD_LD; end
      end
      ST_READ: if (zero) begin nxt = ST_IDLE; capture = 1'b1; end
      ST_TURN: if (zero) begin nxt = ST_WPULSE; ld = 1'b1; ld_val = WP_LD; end
      ST_WPULSE: if (zero) nxt = ST_WREC;
      ST_WREC: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  assign ready = (st == ST_IDLE);
  assign cs_n  = !(st == ST_READ || st == ST_TURN || st == ST_WPULSE);
  assign oe_n  = (st != ST_READ);
  assign we_n  = (st != ST_WPULSE);
  assign drive = (st == ST_WPULSE);

  AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cs_n); // R4
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n); // R4
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready); // R2
endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              ready,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_we,
  input  logic              drive,
  input  logic              capture,
  input  logic              we_n,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              is_write,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              we_q, rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= host_addr;
      wdata_q <= host_wdata;
      we_q    <= host_we;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture) rdata_q <= sram_dq_i;
    end
  end

  assign is_write    = host_we;
  assign sram_addr   = addr_q;
  assign sram_dq_o   = wdata_q;
  assign sram_dq_oe  = drive;
  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready)) |-> $stable(sram_addr)); // R7
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(sram_dq_o)); // R6
  AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> sram_dq_oe); // R6
  AST_RVALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid); // R8
  AST_WRITE_REG_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n) |-> we_q); // R4
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 4,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 12,
  parameter int T_AA_NS       = 12,
  parameter int T_OE_NS       = 6,
  parameter int T_OHZ_NS      = 6,
  parameter int T_WC_NS       = 12,
  parameter int T_WP_NS       = 8,
  parameter int T_CW_NS       = 8,
  parameter int T_AW_NS       = 8,
  parameter int T_DW_NS       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int RD_CYC = rd_cycles(CLK_PERIOD_NS, T_RC_NS, T_AA_NS, T_OE_NS);
  localparam int TA_CYC = ta_cycles(CLK_PERIOD_NS, T_OHZ_NS);
  localparam int WP_CYC = wp_cycles(CLK_PERIOD_NS, T_WP_NS, T_CW_NS, T_AW_NS,
                                    T_DW_NS, T_WC_NS, TA_CYC);
  localparam int CNT_W  = $clog2(max2(RD_CYC, max2(TA_CYC, WP_CYC)) + 1);
  localparam int RUN_W  = $clog2(TA_CYC + 2);

  logic accept, is_write, drive, capture;

  assign accept = host_req && host_ready;

  sram_seq_fsm #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .TA_CYC(TA_CYC), .WP_CYC(WP_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .is_write(is_write),
    .ready(host_ready), .cs_n(sram_cs_n), .we_n(sram_we_n), .oe_n(sram_oe_n),
    .drive(drive), .capture(capture)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .ready(host_ready),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we),
    .drive(drive), .capture(capture), .we_n(sram_we_n), .sram_dq_i(sram_dq_i),
    .is_write(is_write), .sram_addr(sram_addr), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  // cycles that output enable has been high, saturating; watches the turnaround
  logic [RUN_W-1:0] oe_hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             oe_hi_run <= '0;
    else if (!sram_oe_n)                    oe_hi_run <= '0;
    else if (oe_hi_run != RUN_W'(TA_CYC + 1)) oe_hi_run <= oe_hi_run + RUN_W'(1);
  end

  AST_NO_DRIVE_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n); // R5
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (oe_hi_run >= RUN_W'(TA_CYC))); // R5
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe)); // R1
endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;
  localparam int P = 10;

  function automatic int up(input int ns);
    return (ns + P - 1) / P;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int B_RD = mx(mx(up(12), up(12)), mx(up(6), 1));
  localparam int B_TA = mx(up(6), 1);
  localparam int B_WP = mx(mx(mx(up(8), up(8)), mx(up(8), up(6))), mx(up(12) - B_TA, 1));

  localparam logic [4:0] PV_IDLE  = 5'b11110; // ready cs_n we_n oe_n dq_oe
  localparam logic [4:0] PV_READ  = 5'b00100;
  localparam logic [4:0] PV_TURN  = 5'b00110;
  localparam logic [4:0] PV_PULSE = 5'b00011;
  localparam logic [4:0] PV_REC   = 5'b01110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [17:0] host_addr = '0;
  logic [3:0]  host_wdata = '0;
  logic host_ready, host_rvalid, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [3:0]  host_rdata, sram_dq_o, sram_dq_i;
  logic [17:0] sram_addr;

  int total = 0, bad = 0;
  logic [3:0] model_mem [0:1023];
  logic [3:0] exp_mem   [0:1023];

  always #5 clk = ~clk;

  sram_async_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .sram_cs_n(sram_cs_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_addr(sram_addr),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  // behavioural memory: drives in read mode, stores during the write overlap
  assign sram_dq_i = (!sram_cs_n && sram_we_n && !sram_oe_n) ? model_mem[sram_addr[9:0]] : 4'h0;
  always @(posedge clk)
    if (!sram_cs_n && !sram_we_n && sram_dq_oe) model_mem[sram_addr[9:0]] <= sram_dq_o;

  function automatic logic [4:0] pins();
    return {host_ready, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe};
  endfunction

  function automatic logic [17:0] mk_addr(input int a);
    return {8'(a ^ 32'hA5), 10'(a * 3)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // contention monitor for R5
  always @(negedge clk)
    if (rst_n) chk(!(sram_dq_oe && !sram_oe_n), "R5 drive with oe low",
                   {31'd0, sram_dq_oe}, 32'd0);

  task automatic do_write(input logic [17:0] a, input logic [3:0] d, input bit poke);
    logic [4:0] e;
    string tag;
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    for (int i = 1; i <= B_TA + B_WP + 1; i++) begin
      if (i <= B_TA)             begin e = PV_TURN;  tag = "R5 turnaround"; end
      else if (i <= B_TA + B_WP) begin e = PV_PULSE; tag = "R4 pulse"; end
      else                       begin e = PV_REC;   tag = "R4 recovery"; end
      chk(pins() == e, tag, pins(), e);
      chk(sram_addr == a, "R7 addr hold", sram_addr, a);
      if (e == PV_PULSE) chk(sram_dq_o == d, "R6 write data", sram_dq_o, d);
      if (poke && i == 1) begin host_req = 1'b1; host_we = 1'b0; host_addr = ~a; end
      else if (poke && i == 2) host_req = 1'b0;
      @(negedge clk);
    end
    chk(pins() == PV_IDLE, "R2 ready after write", pins(), PV_IDLE);
    exp_mem[a[9:0]] = d;
    if (poke) begin
      @(negedge clk);
      chk(pins() == PV_IDLE && sram_addr == a, "R2 busy request ignored",
          {9'd0, pins(), sram_addr}, {9'd0, PV_IDLE, a});
    end
  endtask

  task automatic do_read(input logic [17:0] a);
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = a; host_wdata = 4'h0;
    @(negedge clk);
    host_req = 1'b0;
    for (int i = 1; i <= B_RD; i++) begin
      chk(pins() == PV_READ, "R3 read strobes", pins(), PV_READ);
      chk(sram_addr == a, "R7 addr hold", sram_addr, a);
      chk(!host_rvalid, "R8 no early valid", host_rvalid, 0);
      @(negedge clk);
    end
    chk(pins() == PV_IDLE && host_rvalid, "R3 read end",
        {host_rvalid, pins()}, {1'b1, PV_IDLE});
    chk(host_rdata == exp_mem[a[9:0]], "R3 read data", host_rdata, exp_mem[a[9:0]]);
    @(negedge clk);
    chk(!host_rvalid, "R8 one-cycle valid", host_rvalid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    summary();
  end

  initial begin
    for (int k = 0; k < 1024; k++) begin model_mem[k] = 4'h0; exp_mem[k] = 4'h0; end
    repeat (3) @(negedge clk);
    chk(pins() == PV_IDLE && !host_rvalid, "R1 pins in reset",
        {host_rvalid, pins()}, {1'b0, PV_IDLE});
    rst_n = 1'b1;
    @(negedge clk);
    chk(pins() == PV_IDLE && !host_rvalid, "R1 pins after reset",
        {host_rvalid, pins()}, {1'b0, PV_IDLE});

    // R4 R6 R7: write sweep, first one with a request made while busy (R2)
    for (int a = 0; a < 256; a++) do_write(mk_addr(a), 4'((a * 7 + 3) & 15), a == 0);
    // R3 R8: back-to-back reads
    for (int a = 0; a < 256; a++) do_read(mk_addr(a));
    // R5: write straight after a read needs turnaround
    for (int a = 0; a < 32; a++) begin
      do_read(mk_addr(a));
      do_write(mk_addr(a), 4'((a * 5 + 9) & 15), a == 7);
      do_read(mk_addr(a));
    end

    // R1: reset during a write returns every pin to idle at once
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = 18'h3FFFF; host_wdata = 4'hF;
    @(negedge clk);
    host_req = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(pins() == PV_IDLE && !host_rvalid, "R1 reset mid write",
        {host_rvalid, pins()}, {1'b0, PV_IDLE});
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(mk_addr(5));
    summary();
  end
endmodule